// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block keeps the two fault-confinement counters of a CAN node and turns them into the node's error state. The surrounding protocol engine reports what happened on the bus as single-cycle strobes. A receive error comes with a class: minor steps the receive counter by 1, severe steps it by 8. The engine also strobes successful receptions, transmit errors and successful transmissions. After bus-off it strobes recovery once the bus has been seen idle. The block knows nothing of bit timing, frame decoding or error detection.

The receive counter is 8 bits wide. The transmit counter is 9 bits wide, and only its low byte is visible. Bit 8 of the transmit counter marks the bus-off state. A 32-bit status word packs both counters, the three state flags and a 3-bit last-error code. Hardware loads that code on each error event. Software can also overwrite it through a small write port.

Top module: `can_fault_counters`

## Requirements
- R1: On `rx_err_i`, the receive counter rises by 1 when `rx_severe_i` is 0 and by 8 when it is 1, saturating at 255.
- R2: On `rx_ok_i` without `rx_err_i`, a receive counter above 128 is loaded with 120. Otherwise it falls by 1, holding at 0. When both strobes are high in one cycle, the error wins.
- R3: The transmit counter is 9 bits wide and `tx_cnt_o` shows bits 7:0. `tx_err_i` adds 8. `tx_ok_i` without `tx_err_i` subtracts 1, holding at 0.
- R4: `warn_o` is 1 exactly when either counter is 96 or more.
- R5: `passive_o` is 1 exactly when either counter is above 127.
- R6: `busoff_o` is 1 exactly when the 9-bit transmit counter is above 255. While it is 1, all four counter strobes are ignored: both counters and the last-error code hold.
- R7: `recover_i` has priority over every other strobe in its cycle. It clears both counters, and so all three flags. The last-error code keeps its value unless software writes it in that cycle.
- R8: `status_o` carries the receive counter in bits 31:24 and the transmit counter's low byte in bits 23:16. It carries the last-error code in bits 6:4, bus-off in bit 2, passive in bit 1 and warning in bit 0. Every other bit is 0.
- R9: An accepted error strobe (`rx_err_i` or `tx_err_i`, not bus-off, no `recover_i`) loads `err_code_i` into the last-error code. Otherwise `lec_we_i` loads `lec_wdata_i`. The hardware load wins when both happen in the same cycle.
- R10: After reset, both counters, all flags and the last-error code are 0. Counters and the code change at the clock edge that samples a strobe. The flags follow within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_err_i | input | 1 | Receive error strobe |
| rx_severe_i | input | 1 | Class of the receive error: 1 selects the step of 8 |
| rx_ok_i | input | 1 | Successful reception strobe |
| tx_err_i | input | 1 | Transmit error strobe |
| tx_ok_i | input | 1 | Successful transmission strobe |
| err_code_i | input | 3 | Error code captured with an error strobe |
| recover_i | input | 1 | Bus-off recovery strobe |
| lec_we_i | input | 1 | Software write enable for the last-error code |
| lec_wdata_i | input | 3 | Software write data for the last-error code |
| rx_cnt_o | output | 8 | Receive error counter |
| tx_cnt_o | output | 8 | Transmit error counter, bits 7:0 |
| warn_o | output | 1 | Warning flag |
| passive_o | output | 1 | Error-passive flag |
| busoff_o | output | 1 | Bus-off flag |
| lec_o | output | 3 | Last-error code |
| status_o | output | 32 | Packed status word |

## Verification
Some properties are checked on every cycle. These cover the step sizes of single events, the snap to 120, the freeze while bus-off, the effect of recovery, the ordering of the flags and the packing of the status word. Other behaviour only the bench's scenarios can show. That covers the exact thresholds at 96, 128 and 256 reached by long runs of events, saturation at both ends of each counter, and the priority between simultaneous strobes. It also covers the last-error code under mixed hardware and software updates, and long pseudo-random event streams compared against an arithmetic model.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int unsigned LEC_W    = 3;
  localparam int unsigned STATUS_W = 32;
  localparam int unsigned RX_LSB   = 24;
  localparam int unsigned TX_LSB   = 16;
  localparam int unsigned LEC_LSB  = 4;
  localparam int unsigned BOFF_BIT = 2;
  localparam int unsigned PASS_BIT = 1;
  localparam int unsigned WARN_BIT = 0;

  typedef logic [LEC_W-1:0] lec_t;

  typedef struct packed {
    logic warn;
    logic passive;
    logic busoff;
  } fc_flags_t;
endpackage

// File: rtl/cfc_rx_counter.sv
module cfc_rx_counter #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned MINOR_STEP  = 1,
  parameter int unsigned SEVERE_STEP = 8,
  parameter int unsigned SNAP_ABOVE  = 128,
  parameter int unsigned SNAP_VAL    = 120
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             hold_i,
  input  logic             err_i,
  input  logic             severe_i,
  input  logic             ok_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W:0]   MAX_W   = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W:0]   MINOR_W = (CNT_W+1)'(MINOR_STEP);
  localparam logic [CNT_W:0]   SEV_W   = (CNT_W+1)'(SEVERE_STEP);
  localparam logic [CNT_W-1:0] SNAP_A  = CNT_W'(SNAP_ABOVE);
  localparam logic [CNT_W-1:0] SNAP_V  = CNT_W'(SNAP_VAL);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + (severe_i ? SEV_W : MINOR_W);
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (!hold_i) begin
      if (err_i) begin
        cnt_d = (sum > MAX_W) ? MAX_W[CNT_W-1:0] : sum[CNT_W-1:0];
      end else if (ok_i) begin
        if (cnt_q > SNAP_A)        cnt_d = SNAP_V;
        else if (cnt_q != '0)      cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cfc_tx_counter.sv
module cfc_tx_counter #(
  parameter int unsigned TX_W    = 9,
  parameter int unsigned ERR_STEP = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            hold_i,
  input  logic            err_i,
  input  logic            ok_i,
  output logic [TX_W-1:0] cnt_o
);
  localparam logic [TX_W:0] MAX_W  = {1'b0, {TX_W{1'b1}}};
  localparam logic [TX_W:0] STEP_W = (TX_W+1)'(ERR_STEP);

  logic [TX_W-1:0] cnt_q, cnt_d;
  logic [TX_W:0]   sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + STEP_W;
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (!hold_i) begin
      if (err_i)                  cnt_d = (sum > MAX_W) ? MAX_W[TX_W-1:0] : sum[TX_W-1:0];
      else if (ok_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cfc_state_flags.sv
module cfc_state_flags
  import cfc_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned TX_W     = 9,
  parameter int unsigned WARN_LIM = 96,
  parameter int unsigned PASS_LIM = 127
) (
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [TX_W-1:0]  tx_cnt_i,
  output fc_flags_t        flags_o
);
  localparam logic [TX_W-1:0] WARN_T = TX_W'(WARN_LIM);
  localparam logic [TX_W-1:0] PASS_T = TX_W'(PASS_LIM);
  localparam logic [TX_W-1:0] BOFF_T = TX_W'((1 << CNT_W) - 1);

  logic [TX_W-1:0] rx_ext;
  assign rx_ext = TX_W'(rx_cnt_i);

  always_comb begin
    flags_o.warn    = (rx_ext >= WARN_T) || (tx_cnt_i >= WARN_T);
    flags_o.passive = (rx_ext >  PASS_T) || (tx_cnt_i >  PASS_T);
    flags_o.busoff  = (tx_cnt_i > BOFF_T);
  end
endmodule

// File: rtl/cfc_lec_reg.sv
module cfc_lec_reg
  import cfc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_ev_i,
  input  lec_t hw_code_i,
  input  logic sw_we_i,
  input  lec_t sw_data_i,
  output lec_t lec_o
);
  lec_t lec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lec_q <= '0;
    else if (hw_ev_i) lec_q <= hw_code_i;
    else if (sw_we_i) lec_q <= sw_data_i;
  end

  assign lec_o = lec_q;
endmodule

// File: rtl/can_fault_counters.sv
module can_fault_counters
  import cfc_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned MINOR_STEP  = 1,
  parameter int unsigned SEVERE_STEP = 8,
  parameter int unsigned TX_STEP     = 8,
  parameter int unsigned SNAP_ABOVE  = 128,
  parameter int unsigned SNAP_VAL    = 120,
  parameter int unsigned WARN_LIM    = 96,
  parameter int unsigned PASS_LIM    = 127
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_err_i,
  input  logic                rx_severe_i,
  input  logic                rx_ok_i,
  input  logic                tx_err_i,
  input  logic                tx_ok_i,
  input  logic [LEC_W-1:0]    err_code_i,
  input  logic                recover_i,
  input  logic                lec_we_i,
  input  logic [LEC_W-1:0]    lec_wdata_i,
  output logic [CNT_W-1:0]    rx_cnt_o,
  output logic [CNT_W-1:0]    tx_cnt_o,
  output logic                warn_o,
  output logic                passive_o,
  output logic                busoff_o,
  output logic [LEC_W-1:0]    lec_o,
  output logic [STATUS_W-1:0] status_o
);
  localparam int unsigned TX_W = CNT_W + 1;

  logic [CNT_W-1:0] rx_cnt;
  logic [TX_W-1:0]  tx_cnt;
  fc_flags_t        flags;
  lec_t             lec;
  logic             frozen;
  logic             hw_ev;

  // bus-off freezes event handling; recovery overrides
  assign frozen = flags.busoff;
  assign hw_ev  = (rx_err_i || tx_err_i) && !frozen && !recover_i;

  cfc_rx_counter #(
    .CNT_W(CNT_W), .MINOR_STEP(MINOR_STEP), .SEVERE_STEP(SEVERE_STEP),
    .SNAP_ABOVE(SNAP_ABOVE), .SNAP_VAL(SNAP_VAL)
  ) u_rx (
    .clk_i, .rst_ni,
    .clear_i (recover_i),
    .hold_i  (frozen),
    .err_i   (rx_err_i),
    .severe_i(rx_severe_i),
    .ok_i    (rx_ok_i),
    .cnt_o   (rx_cnt)
  );

  cfc_tx_counter #(.TX_W(TX_W), .ERR_STEP(TX_STEP)) u_tx (
    .clk_i, .rst_ni,
    .clear_i(recover_i),
    .hold_i (frozen),
    .err_i  (tx_err_i),
    .ok_i   (tx_ok_i),
    .cnt_o  (tx_cnt)
  );

  cfc_state_flags #(
    .CNT_W(CNT_W), .TX_W(TX_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)
  ) u_flags (
    .rx_cnt_i(rx_cnt),
    .tx_cnt_i(tx_cnt),
    .flags_o (flags)
  );

  cfc_lec_reg u_lec (
    .clk_i, .rst_ni,
    .hw_ev_i  (hw_ev),
    .hw_code_i(err_code_i),
    .sw_we_i  (lec_we_i),
    .sw_data_i(lec_wdata_i),
    .lec_o    (lec)
  );

  always_comb begin
    status_o = '0;
    status_o[RX_LSB +: CNT_W]  = rx_cnt;
    status_o[TX_LSB +: CNT_W]  = tx_cnt[CNT_W-1:0];
    status_o[LEC_LSB +: LEC_W] = lec;
    status_o[BOFF_BIT]         = flags.busoff;
    status_o[PASS_BIT]         = flags.passive;
    status_o[WARN_BIT]         = flags.warn;
  end

  assign rx_cnt_o  = rx_cnt;
  assign tx_cnt_o  = tx_cnt[CNT_W-1:0];
  assign warn_o    = flags.warn;
  assign passive_o = flags.passive;
  assign busoff_o  = flags.busoff;
  assign lec_o     = lec;
endmodule

// File: rtl/cfc_checker.sv
module cfc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_err_i,
  input logic        rx_severe_i,
  input logic        rx_ok_i,
  input logic        tx_err_i,
  input logic        tx_ok_i,
  input logic [2:0]  err_code_i,
  input logic        recover_i,
  input logic        lec_we_i,
  input logic [2:0]  lec_wdata_i,
  input logic [7:0]  rx_cnt_o,
  input logic [7:0]  tx_cnt_o,
  input logic        warn_o,
  input logic        passive_o,
  input logic        busoff_o,
  input logic [2:0]  lec_o,
  input logic [31:0] status_o
);
  logic live;
  assign live = !busoff_o && !recover_i;

  p_minor_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && rx_err_i && !rx_severe_i && rx_cnt_o != 8'd255 |=> rx_cnt_o == $past(rx_cnt_o) + 8'd1);

  p_snap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && rx_ok_i && !rx_err_i && rx_cnt_o > 8'd128 |=> rx_cnt_o == 8'd120);

  p_tx_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && tx_ok_i && !tx_err_i && tx_cnt_o == 8'd0 && !passive_o |=> tx_cnt_o == 8'd0);

  p_pass_implies_warn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    passive_o |-> warn_o);

  p_busoff_passive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busoff_o |-> passive_o);

  p_busoff_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busoff_o && !recover_i && !lec_we_i |=> $stable(rx_cnt_o) && $stable(tx_cnt_o) && $stable(lec_o) && busoff_o);

  p_recover_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_i && !lec_we_i |=> rx_cnt_o == 8'd0 && tx_cnt_o == 8'd0 && !warn_o && $stable(lec_o));

  p_status_pack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == {rx_cnt_o, tx_cnt_o, 9'd0, lec_o, 1'b0, busoff_o, passive_o, warn_o});

  p_lec_hw_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && (rx_err_i || tx_err_i) |=> lec_o == $past(err_code_i));
endmodule

bind can_fault_counters cfc_checker u_chk (.*);

// File: tb/can_fault_counters_test.sv
`timescale 1ns/1ps
module can_fault_counters_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_err = 0, rx_sev = 0, rx_ok = 0, tx_err = 0, tx_ok = 0, rec = 0, we = 0;
  logic [2:0] code = 0, wdata = 0;
  logic [7:0] rx_cnt, tx_cnt;
  logic warn, passive, busoff;
  logic [2:0] lec;
  logic [31:0] status;

  int n_chk = 0, n_bad = 0;
  int m_rx = 0, m_tx = 0, m_lec = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  always #5 clk = ~clk;

  can_fault_counters uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_err_i(rx_err), .rx_severe_i(rx_sev), .rx_ok_i(rx_ok),
    .tx_err_i(tx_err), .tx_ok_i(tx_ok), .err_code_i(code),
    .recover_i(rec), .lec_we_i(we), .lec_wdata_i(wdata),
    .rx_cnt_o(rx_cnt), .tx_cnt_o(tx_cnt), .warn_o(warn),
    .passive_o(passive), .busoff_o(busoff), .lec_o(lec), .status_o(status)
  );

  task automatic fail_line(string tag, string what, int act, int exp);
    $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
  endtask

  task automatic check(string tag);
    int e_warn, e_pass, e_boff;
    logic [31:0] e_stat;
    bit bad = 0;
    e_warn = (m_rx >= 96 || m_tx >= 96) ? 1 : 0;
    e_pass = (m_rx > 127 || m_tx > 127) ? 1 : 0;
    e_boff = (m_tx > 255) ? 1 : 0;
    e_stat = {8'(m_rx), 8'(m_tx), 9'd0, 3'(m_lec), 1'b0, 1'(e_boff), 1'(e_pass), 1'(e_warn)};
    n_chk++;
    if (int'(rx_cnt) != m_rx)       begin bad = 1; fail_line(tag, "rx_cnt", rx_cnt, m_rx); end
    if (int'(tx_cnt) != (m_tx & 255)) begin bad = 1; fail_line(tag, "tx_cnt", tx_cnt, m_tx & 255); end
    if (int'(warn) != e_warn)       begin bad = 1; fail_line("R4", "warn", warn, e_warn); end
    if (int'(passive) != e_pass)    begin bad = 1; fail_line("R5", "passive", passive, e_pass); end
    if (int'(busoff) != e_boff)     begin bad = 1; fail_line("R6", "busoff", busoff, e_boff); end
    if (int'(lec) != m_lec)         begin bad = 1; fail_line("R9", "lec", lec, m_lec); end
    if (status != e_stat)           begin bad = 1; fail_line("R8", "status", status, e_stat); end
    if (bad) n_bad++;
  endtask

  // inputs set at a falling edge, model advanced and outputs compared one cycle later
  task automatic step(bit re, bit sev, bit ro, bit te, bit to, bit rc, bit w,
                      logic [2:0] c, logic [2:0] wd, string tag);
    bit boff;
    rx_err = re; rx_sev = sev; rx_ok = ro; tx_err = te; tx_ok = to;
    rec = rc; we = w; code = c; wdata = wd;
    @(negedge clk);
    boff = (m_tx > 255);
    if (rc) begin
      m_rx = 0; m_tx = 0;
    end else if (!boff) begin
      if (re)      m_rx = (m_rx + (sev ? 8 : 1) > 255) ? 255 : m_rx + (sev ? 8 : 1);
      else if (ro) m_rx = (m_rx > 128) ? 120 : ((m_rx > 0) ? m_rx - 1 : 0);
      if (te)      m_tx = m_tx + 8;
      else if (to) m_tx = (m_tx > 0) ? m_tx - 1 : 0;
    end
    if (!rc && !boff && (re || te)) m_lec = c;
    else if (w)                     m_lec = wd;
    rx_err = 0; rx_sev = 0; rx_ok = 0; tx_err = 0; tx_ok = 0; rec = 0; we = 0;
    check(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R10");                          // R10 reset state
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check("R10");

    // R1 minor sweep through 96, 128 and saturation at 255
    for (int i = 0; i < 260; i++) step(1,0,0,0,0,0,0, 3'(i), 0, "R1");
    // R2 success sweep: snap from 255 to 120, then down past 0
    for (int i = 0; i < 125; i++) step(0,0,1,0,0,0,0, 0, 0, "R2");
    // R1 severe sweep to saturation
    for (int i = 0; i < 36; i++) step(1,1,0,0,0,0,0, 3'd5, 0, "R1");
    // R2 error wins over success
    step(1,0,1,0,0,0,0, 3'd2, 0, "R2");
    for (int i = 0; i < 3; i++) step(0,0,1,0,0,0,0, 0, 0, "R2");
    // R2 snap boundary: 129 snaps, 128 decrements
    step(0,0,0,0,0,1,0, 0, 0, "R7");
    for (int i = 0; i < 16; i++) step(1,1,0,0,0,0,0, 3'd1, 0, "R1");
    step(1,0,0,0,0,0,0, 3'd1, 0, "R1");
    step(0,0,1,0,0,0,0, 0, 0, "R2");       // 129 -> 120
    step(0,0,0,0,0,1,0, 0, 0, "R7");
    for (int i = 0; i < 16; i++) step(1,1,0,0,0,0,0, 3'd1, 0, "R1");
    step(0,0,1,0,0,0,0, 0, 0, "R2");       // 128 -> 127

    step(0,0,0,0,0,1,0, 0, 0, "R7");
    // R3 floor, then climb to bus-off
    step(0,0,0,0,1,0,0, 0, 0, "R3");
    for (int i = 0; i < 32; i++) step(0,0,0,1,0,0,0, 3'(i), 0, "R3");
    // R6 events ignored while bus-off
    step(1,1,0,0,0,0,0, 3'd7, 0, "R6");
    step(0,0,0,0,1,0,0, 0, 0, "R6");
    step(0,0,1,1,0,0,0, 3'd6, 0, "R6");
    step(0,0,0,0,0,0,1, 0, 3'd4, "R9");    // software write still lands
    // R7 recovery wins over simultaneous events
    step(1,1,0,1,0,1,0, 3'd3, 0, "R7");
    step(0,0,0,1,0,0,0, 3'd1, 0, "R3");
    step(0,0,0,1,1,0,0, 3'd1, 0, "R3");    // error wins over success
    for (int i = 0; i < 20; i++) step(0,0,0,0,1,0,0, 0, 0, "R3");
    // R9 software and hardware ordering
    step(0,0,0,0,0,0,1, 0, 3'd6, "R9");
    step(1,0,0,0,0,0,1, 3'd2, 3'd5, "R9");
    step(0,0,0,1,0,0,1, 3'd3, 3'd7, "R9");
    step(0,0,0,0,0,1,1, 0, 3'd1, "R7");

    // R6 mixed pseudo-random stream against the model
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1], lfsr[2], lfsr[3] & lfsr[4], lfsr[5],
           (lfsr[11:6] == 6'd0), lfsr[7] & lfsr[8], lfsr[10:8], lfsr[13:11], "R6");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule